// File: doc/BRIEF.md
# Two-Wire Slave Register Port for a 10-Bit DAC

This block is the digital front end of a voltage-output DAC. It listens on a two-wire serial bus as a slave only. The bus lines reach it as open-drain inputs, and a fast system clock oversamples them. The block keeps three pieces of state: a DAC code register, a configuration register that holds a standby bit, and a register pointer. The pointer persists from one transaction to the next.

A host first writes a command byte, which chooses the register. It then either writes one or two data bytes, or turns the bus around with a repeated START and reads the register back. A read can also come as a bare address-with-read transfer, and that returns whatever register the last command chose. The block presents the code to the converter as one parallel word. Next to it is a one-cycle strobe that marks every change of that word, and a standby level that the analog side uses to power down. The serial port keeps working in standby.

Top module: `smb_dac_regif`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal 1001000. After any other address it leaves SDA released (sda_oe_n = 1) until the next START.
- R2: A START (SDA falling while SCL is high) at any point returns the block to receiving an address. A STOP (SDA rising while SCL is high) releases SDA and ends the transfer.
- R3: Bytes arrive MSB first. For every accepted address byte, command byte or data byte, the slave pulls SDA low during the 9th clock only, and it releases SDA before the next byte.
- R4: Command byte 0x00 selects the code register and 0x01 selects the configuration register. Any other command value is not acknowledged and leaves the pointer unchanged.
- R5: A two-byte write to the code register applies {first[1:0], second[7:0]} as one update when the second byte's acknowledge clock ends. No change happens after the first byte alone. code_upd pulses for exactly one cycle for every change of dac_code.
- R6: A one-byte write to the code register followed by STOP replaces code[7:0] and keeps code[9:8].
- R7: Bit 0 of a configuration write sets standby (1 = standby, 0 = normal). A second configuration data byte, like a third code data byte, is not acknowledged and has no effect. Writes and reads keep working in standby.
- R8: A read through a repeated START returns {000000, code[9:8]} and then code[7:0] for the code register, or {0000000, standby} for the configuration register. The master's NACK ends the read, and SDA is released after it.
- R9: An address-with-read transfer straight after START returns the register chosen by the most recent accepted command, even when that command came in an earlier transaction.
- R10: After reset dac_code = 0, standby = 0, the pointer selects the code register, code_upd = 0 and SDA is released.
- R11: A START or STOP in the middle of a byte, or a START after only the first of two code bytes, discards the partial write. Both the code and the pointer keep their earlier values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_n | output | 1 | Active-low enable that pulls SDA to ground |
| dac_code | output | 10 | Code word presented to the converter |
| standby | output | 1 | Standby request, 1 powers the converter down |
| code_upd | output | 1 | One-cycle strobe on each change of dac_code |

## Verification
Several properties are checked on every cycle. The slave drives SDA only inside the acknowledge slot while it receives, and it stays silent while it is off the bus. A START always lands in address reception, a STOP always frees the line, and dac_code never moves without code_upd, which never lasts two cycles. Other behaviour can only be shown by the bench's directed transactions: the byte-level protocol, the values that come back on reads, the pointer surviving between transactions, one-byte versus two-byte commits, and discarded partial writes.

// File: rtl/smb_dac_pkg.sv
package smb_dac_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_ADDR  = 3'd1,
      PH_CMD   = 3'd2,
      PH_WDATA = 3'd3,
      PH_RDATA = 3'd4
   } phase_t;

   typedef enum logic {
      SEL_CODE = 1'b0,
      SEL_CFG  = 1'b1
   } regsel_t;

   localparam logic [7:0] CMD_SEL_CODE = 8'h00;
   localparam logic [7:0] CMD_SEL_CFG  = 8'h01;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_s,
   output logic line_q,
   output logic rise,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("smb_line_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-1:0], line_i};
   end

   assign line_s = pipe[STAGES-1];
   assign line_q = pipe[STAGES];
   assign rise   = line_s & ~line_q;
   assign fall   = ~line_s & line_q;
endmodule

// File: rtl/smb_byte_engine.sv
module smb_byte_engine
   import smb_dac_pkg::*;
#(
   parameter int          ADDR_W   = 7,
   parameter logic [6:0]  SLV_ADDR = 7'b1001000,
   parameter int          MAX_CODE_BYTES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       sda_s,
   input  logic       start_det,
   input  logic       stop_det,
   input  regsel_t    ptr,
   input  logic [7:0] tx_byte,
   output logic       rd_idx,
   output logic       drv_low,
   output logic       ptr_we,
   output regsel_t    ptr_val,
   output logic       wr_stb,
   output logic       wr_idx,
   output logic [7:0] wr_byte,
   output logic       bound_stop,
   output logic       any_cond
);
   if (ADDR_W != 7) begin : g_bad_addr
      $error("smb_byte_engine: only 7-bit addressing is supported");
   end
   if (MAX_CODE_BYTES < 1 || MAX_CODE_BYTES > 2) begin : g_bad_bytes
      $error("smb_byte_engine: MAX_CODE_BYTES must be 1 or 2");
   end

   localparam int CNT_W = 4;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(8);
   localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(9);

   phase_t           phase;
   logic [CNT_W-1:0] bit_cnt;
   logic [7:0]       shreg;
   logic [7:0]       txsh;
   logic             ack_q;
   logic             mack;
   logic [1:0]       wr_cnt;
   logic             accept_c;

   always_comb begin
      accept_c = 1'b0;
      unique case (phase)
         PH_ADDR:  accept_c = (shreg[7:1] == SLV_ADDR);
         PH_CMD:   accept_c = (shreg == CMD_SEL_CODE) || (shreg == CMD_SEL_CFG);
         PH_WDATA: accept_c = (ptr == SEL_CFG) ? (wr_cnt == 2'd0)
                                               : (wr_cnt < 2'(MAX_CODE_BYTES));
         default:  accept_c = 1'b0;
      endcase
   end

   assign any_cond   = start_det | stop_det;
   assign bound_stop = stop_det & (phase == PH_WDATA) & (bit_cnt <= CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         bit_cnt <= '0;
         shreg   <= '0;
         txsh    <= '0;
         ack_q   <= 1'b0;
         mack    <= 1'b0;
         wr_cnt  <= '0;
         rd_idx  <= 1'b0;
         drv_low <= 1'b0;
         ptr_we  <= 1'b0;
         ptr_val <= SEL_CODE;
         wr_stb  <= 1'b0;
         wr_idx  <= 1'b0;
         wr_byte <= '0;
      end else begin
         ptr_we <= 1'b0;
         wr_stb <= 1'b0;
         if (start_det) begin
            phase   <= PH_ADDR;
            bit_cnt <= '0;
            drv_low <= 1'b0;
            wr_cnt  <= '0;
            rd_idx  <= 1'b0;
         end else if (stop_det) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            drv_low <= 1'b0;
         end else begin
            unique case (phase)
               PH_IDLE: ;
               PH_ADDR, PH_CMD, PH_WDATA: begin
                  if (scl_rise && bit_cnt < LAST_BIT) begin
                     shreg   <= {shreg[6:0], sda_s};
                     bit_cnt <= bit_cnt + CNT_W'(1);
                  end
                  if (scl_fall && bit_cnt == LAST_BIT) begin
                     if (accept_c) begin
                        drv_low <= 1'b1;
                        ack_q   <= 1'b1;
                        bit_cnt <= ACK_SLOT;
                     end else begin
                        phase   <= PH_IDLE;
                        bit_cnt <= '0;
                     end
                  end else if (scl_fall && bit_cnt == ACK_SLOT) begin
                     drv_low <= 1'b0;
                     bit_cnt <= '0;
                     ack_q   <= 1'b0;
                     if (phase == PH_ADDR) begin
                        if (shreg[0]) begin
                           phase   <= PH_RDATA;
                           txsh    <= tx_byte;
                           drv_low <= ~tx_byte[7];
                        end else begin
                           phase <= PH_CMD;
                        end
                     end else if (phase == PH_CMD) begin
                        ptr_we  <= 1'b1;
                        ptr_val <= shreg[0] ? SEL_CFG : SEL_CODE;
                        phase   <= PH_WDATA;
                        wr_cnt  <= '0;
                     end else begin
                        wr_stb  <= 1'b1;
                        wr_idx  <= wr_cnt[0];
                        wr_byte <= shreg;
                        wr_cnt  <= wr_cnt + 2'd1;
                     end
                  end
               end
               PH_RDATA: begin
                  if (scl_rise) begin
                     if (bit_cnt < LAST_BIT) begin
                        bit_cnt <= bit_cnt + CNT_W'(1);
                     end else if (bit_cnt == LAST_BIT) begin
                        mack    <= ~sda_s;
                        bit_cnt <= ACK_SLOT;
                     end
                  end
                  if (scl_fall) begin
                     if (bit_cnt != '0 && bit_cnt < LAST_BIT) begin
                        txsh    <= {txsh[6:0], 1'b0};
                        drv_low <= ~txsh[6];
                     end else if (bit_cnt == LAST_BIT) begin
                        drv_low <= 1'b0;
                        rd_idx  <= 1'b1;
                     end else if (bit_cnt == ACK_SLOT) begin
                        bit_cnt <= '0;
                        if (mack) begin
                           txsh    <= tx_byte;
                           drv_low <= ~tx_byte[7];
                        end else begin
                           phase <= PH_IDLE;
                        end
                     end
                  end
               end
               default: phase <= PH_IDLE;
            endcase
         end
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> !drv_low); // R1
   AST_RX_ACK_SLOT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_low && phase != PH_RDATA) |-> (bit_cnt == ACK_SLOT)); // R3
   AST_STOP_FREES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det && !start_det |=> (!drv_low && phase == PH_IDLE)); // R2
   AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (phase == PH_ADDR && bit_cnt == '0 && !drv_low)); // R2
endmodule

// File: rtl/smb_dac_regs.sv
module smb_dac_regs
   import smb_dac_pkg::*;
#(
   parameter int CODE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ptr_we,
   input  regsel_t           ptr_val,
   input  logic              wr_stb,
   input  logic              wr_idx,
   input  logic [7:0]        wr_byte,
   input  logic              bound_stop,
   input  logic              any_cond,
   input  logic              rd_idx,
   output regsel_t           ptr,
   output logic [7:0]        tx_byte,
   output logic [CODE_W-1:0] code,
   output logic              shdn,
   output logic              code_upd
);
   if (CODE_W < 9 || CODE_W > 16) begin : g_bad_code_w
      $error("smb_dac_regs: CODE_W must be within 9..16");
   end

   localparam int HI_W = CODE_W - 8;

   logic [7:0] pend;
   logic       pend_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr      <= SEL_CODE;
         code     <= '0;
         shdn     <= 1'b0;
         pend     <= '0;
         pend_v   <= 1'b0;
         code_upd <= 1'b0;
      end else begin
         code_upd <= 1'b0;
         if (ptr_we) ptr <= ptr_val;
         if (bound_stop && pend_v) begin
            code[7:0] <= pend;
            code_upd  <= (code[7:0] != pend);
            pend_v    <= 1'b0;
         end else if (any_cond) begin
            pend_v <= 1'b0;
         end else if (wr_stb) begin
            if (ptr == SEL_CFG) begin
               shdn <= wr_byte[0];
            end else if (!wr_idx) begin
               pend   <= wr_byte;
               pend_v <= 1'b1;
            end else if (pend_v) begin
               code     <= {pend[HI_W-1:0], wr_byte};
               code_upd <= (code != {pend[HI_W-1:0], wr_byte});
               pend_v   <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      if (ptr == SEL_CFG)  tx_byte = {7'b0, shdn};
      else if (!rd_idx)    tx_byte = 8'(code[CODE_W-1:8]);
      else                 tx_byte = code[7:0];
   end

   AST_CODE_MOVES_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (code != $past(code)) |-> code_upd); // R5
   AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      code_upd |=> !code_upd); // R5
endmodule

// File: rtl/smb_dac_regif.sv
module smb_dac_regif
   import smb_dac_pkg::*;
#(
   parameter int         CODE_W      = 10,
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] SLV_ADDR    = 7'b1001000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_n,
   output logic [CODE_W-1:0] dac_code,
   output logic              standby,
   output logic              code_upd
);
   logic scl_s, scl_q, scl_rise, scl_fall;
   logic sda_s, sda_q, sda_rise, sda_fall;
   logic start_det, stop_det;
   logic drv_low, rd_idx, ptr_we, wr_stb, wr_idx, bound_stop, any_cond;
   regsel_t ptr, ptr_val;
   logic [7:0] tx_byte, wr_byte;

   smb_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i),
      .line_s(scl_s), .line_q(scl_q), .rise(scl_rise), .fall(scl_fall));

   smb_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i),
      .line_s(sda_s), .line_q(sda_q), .rise(sda_rise), .fall(sda_fall));

   assign start_det = scl_s & scl_q & sda_fall;
   assign stop_det  = scl_s & scl_q & sda_rise;

   smb_byte_engine #(.ADDR_W(7), .SLV_ADDR(SLV_ADDR), .MAX_CODE_BYTES(2)) u_engine (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
      .ptr(ptr), .tx_byte(tx_byte), .rd_idx(rd_idx), .drv_low(drv_low),
      .ptr_we(ptr_we), .ptr_val(ptr_val), .wr_stb(wr_stb), .wr_idx(wr_idx),
      .wr_byte(wr_byte), .bound_stop(bound_stop), .any_cond(any_cond));

   smb_dac_regs #(.CODE_W(CODE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_val(ptr_val),
      .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_byte(wr_byte),
      .bound_stop(bound_stop), .any_cond(any_cond), .rd_idx(rd_idx),
      .ptr(ptr), .tx_byte(tx_byte), .code(dac_code), .shdn(standby),
      .code_upd(code_upd));

   assign sda_oe_n = ~drv_low;
endmodule

// File: tb/test_smb_dac_regif.sv
module test_smb_dac_regif;
   localparam int Q = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe_n, standby, code_upd;
   logic [9:0] dac_code;
   wire  sda_bus = sda_m & sda_oe_n;

   int n_chk = 0;
   int n_bad = 0;
   int upd_cnt = 0;
   int quiet_viol = 0;
   logic watch_quiet = 1'b0;

   always #2 clk = ~clk;

   smb_dac_regif i_smb_dac_regif (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe_n(sda_oe_n), .dac_code(dac_code), .standby(standby),
      .code_upd(code_upd));

   always @(posedge clk) begin
      if (code_upd) upd_cnt <= upd_cnt + 1;
      if (watch_quiet && !sda_oe_n) quiet_viol <= quiet_viol + 1;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
      sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic put_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) put_bit(b[i]);
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
      ack = ~sda_bus;
      scl_m = 1'b0; wq();
   endtask

   task automatic get_byte(input logic give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(); scl_m = 1'b1; wq(); b[i] = sda_bus; scl_m = 1'b0;
      end
      wq(); sda_m = ~give_ack; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
      sda_m = 1'b1;
   endtask

   task automatic t_reset();
      chk("R10 code", int'(dac_code), 0);
      chk("R10 standby", int'(standby), 0);
      chk("R10 sda released", int'(sda_oe_n), 1);
      chk("R10 strobe", int'(code_upd), 0);
   endtask

   task automatic t_bad_address();
      logic a;
      bus_start();
      put_byte(8'h92, a);
      chk("R1 foreign address nacked", int'(a), 0);
      watch_quiet = 1'b1;
      put_byte(8'h00, a);
      put_byte(8'h55, a);
      watch_quiet = 1'b0;
      chk("R1 silent after foreign address", quiet_viol, 0);
      bus_stop();
      chk("R1 code untouched", int'(dac_code), 0);
   endtask

   task automatic t_two_byte_write();
      logic a;
      int u0;
      u0 = upd_cnt;
      bus_start();
      put_byte(8'h90, a); chk("R3 address ack", int'(a), 1);
      put_byte(8'h00, a); chk("R4 command 0x00 ack", int'(a), 1);
      put_byte(8'h02, a); chk("R3 first data ack", int'(a), 1);
      chk("R5 no change after first byte", int'(dac_code), 0);
      put_byte(8'h5A, a); chk("R3 second data ack", int'(a), 1);
      chk("R5 two-byte value", int'(dac_code), 'h25A);
      chk("R5 single strobe", upd_cnt - u0, 1);
      chk("R3 line released after ack", int'(sda_oe_n), 1);
      put_byte(8'h11, a); chk("R7 third code byte nacked", int'(a), 0);
      bus_stop();
      chk("R7 third byte ignored", int'(dac_code), 'h25A);
   endtask

   task automatic t_one_byte_write();
      logic a;
      bus_start();
      put_byte(8'h90, a); put_byte(8'h00, a); put_byte(8'hC3, a);
      bus_stop(); wq();
      chk("R6 one-byte keeps upper bits", int'(dac_code), 'h2C3);
   endtask

   task automatic t_read_code();
      logic a;
      logic [7:0] b;
      bus_start();
      put_byte(8'h90, a); put_byte(8'h00, a);
      bus_start();
      put_byte(8'h91, a); chk("R8 read address ack", int'(a), 1);
      get_byte(1'b1, b); chk("R8 upper byte", int'(b), 'h02);
      get_byte(1'b0, b); chk("R8 lower byte", int'(b), 'hC3);
      chk("R8 released after nack", int'(sda_oe_n), 1);
      bus_stop();
   endtask

   task automatic t_config();
      logic a;
      logic [7:0] b;
      bus_start();
      put_byte(8'h90, a); put_byte(8'h01, a); chk("R4 command 0x01 ack", int'(a), 1);
      put_byte(8'hFF, a); chk("R7 config byte ack", int'(a), 1);
      chk("R7 standby set", int'(standby), 1);
      put_byte(8'h00, a); chk("R7 second config byte nacked", int'(a), 0);
      bus_stop();
      chk("R7 standby kept", int'(standby), 1);
      bus_start();
      put_byte(8'h91, a);
      get_byte(1'b0, b); chk("R9 receive-byte gives config", int'(b), 1);
      bus_stop();
   endtask

   task automatic t_bad_command();
      logic a;
      logic [7:0] b;
      bus_start();
      put_byte(8'h90, a); put_byte(8'h07, a);
      chk("R4 unknown command nacked", int'(a), 0);
      bus_stop();
      bus_start();
      put_byte(8'h91, a);
      get_byte(1'b0, b); chk("R4 pointer kept on config", int'(b), 1);
      bus_stop();
   endtask

   task automatic t_standby_write();
      logic a;
      logic [7:0] b;
      bus_start();
      put_byte(8'h90, a); put_byte(8'h00, a);
      put_byte(8'h03, a); put_byte(8'hFF, a);
      bus_stop();
      chk("R7 write works in standby", int'(dac_code), 'h3FF);
      bus_start();
      put_byte(8'h91, a);
      get_byte(1'b0, b); chk("R9 receive-byte gives code upper", int'(b), 'h03);
      bus_stop();
   endtask

   task automatic t_abort();
      logic a;
      logic [7:0] b;
      int u0;
      u0 = upd_cnt;
      bus_start();
      put_byte(8'h90, a); put_byte(8'h00, a); put_byte(8'h01, a);
      put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
      bus_stop(); wq();
      chk("R11 stop mid-byte discards", int'(dac_code), 'h3FF);
      chk("R11 no strobe on abort", upd_cnt - u0, 0);
      bus_start();
      put_byte(8'h90, a); put_byte(8'h00, a); put_byte(8'h01, a);
      bus_start();
      put_byte(8'h91, a); chk("R2 address after repeated start", int'(a), 1);
      get_byte(1'b1, b); chk("R11 upper after start abort", int'(b), 'h03);
      get_byte(1'b0, b); chk("R11 lower after start abort", int'(b), 'hFF);
      bus_stop();
      bus_start();
      put_byte(8'h90, a); put_byte(8'h01, a); put_byte(8'h00, a);
      bus_stop();
      chk("R7 standby cleared", int'(standby), 0);
      chk("R2 line free after stop", int'(sda_oe_n), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_bad_address();
      t_two_byte_write();
      t_one_byte_write();
      t_read_code();
      t_config();
      t_bad_command();
      t_standby_write();
      t_abort();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule